// File: doc/BRIEF.md
# Dual-Channel DAC Waveform Generator

This block computes the digital code that a DAC channel converts, once per conversion trigger. Each channel adds a wave term to a base value. The wave term comes from a triangle counter or from a masked pseudo-random shift register, and the sum wraps modulo 2^DATA_W. A single 4-bit amplitude selector serves both sources. In triangle mode it sets the peak of the ramp. In noise mode it sets how many low shift-register bits pass through.

Each channel is configured through one 16-bit half of a control word. Channel c uses bits `[16*c+15:16*c]`, so every field of the second channel sits 16 bits above the same field of the first. A conversion fires on a software pulse or on one of several hardware trigger lines, as the trigger-select field chooses. When triggering is turned off, the channel output simply follows the base value. The channels are instances of the same logic and keep their state separately.

Top module: `wavegen_dual`

## Requirements
- R1: In a channel's 16-bit control half, bits [5:4] select the wave mode: 00 means no generation, 01 means noise, 10 means triangle, and 11 acts like 00. Channel 2 uses the same layout in control bits [31:16].
- R2: Control bit 0 enables triggering. Bits [3:1] pick the trigger source: 0 is that channel's software pulse, and k = 1..7 is hardware line `hw_trig_i[k-1]`. A pulse on any other source has no effect.
- R3: In triangle mode the counter starts at 0 and changes by exactly 1 on each trigger. It rises until it reaches the peak, then falls back to 0, and then repeats. With amplitude selector n (bits [9:6]), the peak is 2^(n+1)-1. Any n of 11 or more gives 4095.
- R4: In noise mode the wave term is the shift register with only bits [n:0] kept. Any n of 11 or more keeps all 12 bits.
- R5: The noise source is a 12-bit shift register reset to 0xAAA. It shifts left, and the bit fed into position 0 is b11^b10^b9^b3. It advances only on triggers taken in noise mode and never holds zero.
- R6: On a trigger, the output register loads (base + wave term) mod 4096 at the same clock edge that samples the trigger. The wave term is the generator's value after its step.
- R7: With mode 00 or 11, each trigger loads the base value unchanged.
- R8: With triggering enabled and no trigger, the output holds even when the base value changes.
- R9: With the trigger-enable bit clear, the output loads the base value on every clock, and neither generator advances.
- R10: Any change of the wave-mode field clears the triangle counter to 0 and sets its direction to rising. No triangle step is taken in that cycle.
- R11: While reset is asserted, every output code is 0.
- R12: Triggers and configuration of one channel do not change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | NUM_CH*16 | Per-channel control halves (enable, source, mode, amplitude) |
| base_i | input | NUM_CH*DATA_W | Per-channel base value, channel c at `[c*DATA_W +: DATA_W]` |
| sw_trig_i | input | NUM_CH | Software trigger pulse, one bit per channel |
| hw_trig_i | input | N_HW_TRIG | Hardware trigger pulses shared by all channels |
| code_o | output | NUM_CH*DATA_W | Registered output code per channel |

## Verification
The bench builds the block with its defaults: DATA_W of 12, two channels, seven hardware trigger lines and seed 0xAAA. With these values the full 4095 triangle peak can be reached in about eight thousand cycles, so the bench can check the turn at the top and the saturation of the selector for n above 11. The default widths also let the bench test both ends of the trigger-select range (hardware lines 1 and 7) and the position of the second channel's fields 16 bits higher. The 12-bit wrap is reached both by a triangle term added to base 0xFFE and by noise terms added to base 0x800.

// File: rtl/wg_pkg.sv
package wg_pkg;

  // Width of one channel's slice of the control word.
  localparam int CH_STRIDE = 16;

  // Field positions inside a channel's control half.
  localparam int TEN_POS  = 0;
  localparam int TSEL_LSB = 1;
  localparam int TSEL_W   = 3;
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 2;
  localparam int AMP_LSB  = 6;
  localparam int AMP_W    = 4;
  localparam int CFG_USED = AMP_LSB + AMP_W;

  typedef enum logic [MODE_W-1:0] {
    WM_NONE  = 2'b00,
    WM_NOISE = 2'b01,
    WM_TRI   = 2'b10,
    WM_RSVD  = 2'b11
  } wave_mode_e;

  typedef struct packed {
    logic              trig_en;
    logic [TSEL_W-1:0] tsel;
    wave_mode_e        mode;
    logic [AMP_W-1:0]  amp;
  } chan_cfg_t;

  function automatic chan_cfg_t unpack_cfg(input logic [CFG_USED-1:0] f);
    chan_cfg_t c;
    c.trig_en = f[TEN_POS];
    c.tsel    = f[TSEL_LSB +: TSEL_W];
    c.mode    = wave_mode_e'(f[MODE_LSB +: MODE_W]);
    c.amp     = f[AMP_LSB +: AMP_W];
    return c;
  endfunction

endpackage

// File: rtl/wg_amp_mask.sv
// Expands the amplitude selector n into a mask of ones in bits [n:0].
// The same mask is the triangle peak and the noise bit mask.
module wg_amp_mask #(
  parameter int DATA_W = 12
) (
  input  logic [wg_pkg::AMP_W-1:0] amp_i,
  output logic [DATA_W-1:0]        mask_o
);

  localparam int AMP_W = wg_pkg::AMP_W;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign mask_o[i] = 1'b1;
    end else begin : g_upper
      assign mask_o[i] = (32'(amp_i) >= i);
    end
  end

  logic unused_amp;
  assign unused_amp = ^{AMP_W{1'b0}};

endmodule

// File: rtl/wg_trig_sel.sv
// Picks the conversion trigger for one channel.
module wg_trig_sel #(
  parameter int N_HW = 7
) (
  input  logic                      trig_en_i,
  input  logic [wg_pkg::TSEL_W-1:0] tsel_i,
  input  logic                      sw_i,
  input  logic [N_HW-1:0]           hw_i,
  output logic                      fire_o
);

  localparam int N_SRC = 1 << wg_pkg::TSEL_W;

  logic [N_SRC-1:0] src;

  assign src[0] = sw_i;

  for (genvar k = 1; k < N_SRC; k++) begin : g_src
    if (k <= N_HW) begin : g_line
      assign src[k] = hw_i[k-1];
    end else begin : g_none
      assign src[k] = 1'b0;
    end
  end

  assign fire_o = trig_en_i & src[tsel_i];

endmodule

// File: rtl/wg_tri_gen.sv
// Up/down triangle counter. term_o is the value after this cycle's step.
module wg_tri_gen #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] peak_i,
  output logic [DATA_W-1:0] term_o
);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              up_q, up_d;
  logic              cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (clr_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (step_i) begin
      if (up_q) begin
        if (cnt_q >= peak_i) begin
          up_d  = 1'b0;
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          up_d  = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_en = clr_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign term_o = cnt_d;

  AST_TRI_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1))); // R3
  AST_TRI_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R9
  AST_TRI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && up_q)); // R10

endmodule

// File: rtl/wg_lfsr_gen.sv
// Fibonacci shift register noise source. term_o is the masked value after the step.
module wg_lfsr_gen #(
  parameter int                DATA_W   = 12,
  parameter logic [DATA_W-1:0] SEED     = 12'hAAA,
  parameter logic [DATA_W-1:0] TAP_MASK = 12'hE08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] term_o
);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic              fb;

  assign fb = ^(sr_q & TAP_MASK);

  always_comb begin
    sr_d = sr_q;
    if (step_i) begin
      sr_d = {sr_q[DATA_W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= SEED;
    end else if (step_i) begin
      sr_q <= sr_d;
    end
  end

  assign term_o = sr_d & mask_i;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0); // R5
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(sr_q)); // R5

endmodule

// File: rtl/wg_channel.sv
// One generator channel: trigger select, two sources, mode tracking, output register.
module wg_channel
  import wg_pkg::*;
#(
  parameter int                DATA_W = 12,
  parameter int                N_HW   = 7,
  parameter logic [DATA_W-1:0] SEED   = 12'hAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              sw_i,
  input  logic [N_HW-1:0]   hw_i,
  output logic [DATA_W-1:0] code_o
);

  logic              fire;
  logic [DATA_W-1:0] amp_mask;
  logic [DATA_W-1:0] tri_term, noise_term;
  logic [DATA_W-1:0] wave_term;
  logic              mode_chg;
  logic              tri_step, noise_step;
  wave_mode_e        mode_q;
  logic [DATA_W-1:0] code_q, code_d;
  logic              code_ld;

  wg_trig_sel #(.N_HW(N_HW)) u_trig (
    .trig_en_i (cfg_i.trig_en),
    .tsel_i    (cfg_i.tsel),
    .sw_i      (sw_i),
    .hw_i      (hw_i),
    .fire_o    (fire)
  );

  wg_amp_mask #(.DATA_W(DATA_W)) u_mask (
    .amp_i  (cfg_i.amp),
    .mask_o (amp_mask)
  );

  assign mode_chg   = (cfg_i.mode != mode_q);
  assign tri_step   = fire && (cfg_i.mode == WM_TRI) && !mode_chg;
  assign noise_step = fire && (cfg_i.mode == WM_NOISE);

  wg_tri_gen #(.DATA_W(DATA_W)) u_tri (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (mode_chg),
    .step_i (tri_step),
    .peak_i (amp_mask),
    .term_o (tri_term)
  );

  wg_lfsr_gen #(.DATA_W(DATA_W), .SEED(SEED)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (noise_step),
    .mask_i (amp_mask),
    .term_o (noise_term)
  );

  always_comb begin
    wave_term = '0;
    if (cfg_i.trig_en) begin
      unique case (cfg_i.mode)
        WM_TRI:   wave_term = tri_term;
        WM_NOISE: wave_term = noise_term;
        default:  wave_term = '0;
      endcase
    end
  end

  assign code_d  = base_i + wave_term;
  assign code_ld = !cfg_i.trig_en || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_NONE;
    end else begin
      mode_q <= cfg_i.mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_ld) begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  AST_FIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> cfg_i.trig_en); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.trig_en && !fire) |=> $stable(code_q)); // R8
  AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.trig_en |=> (code_q == $past(base_i))); // R9
  AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cfg_i.mode == WM_NONE || cfg_i.mode == WM_RSVD)) |=> (code_q == $past(base_i))); // R7

endmodule

// File: rtl/wavegen_dual.sv
// Multi-channel DAC waveform generator top.
module wavegen_dual #(
  parameter int                DATA_W    = 12,
  parameter int                NUM_CH    = 2,
  parameter int                N_HW_TRIG = 7,
  parameter logic [DATA_W-1:0] SEED      = 12'hAAA
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_CH*wg_pkg::CH_STRIDE-1:0]  ctrl_i,
  input  logic [NUM_CH*DATA_W-1:0]             base_i,
  input  logic [NUM_CH-1:0]                    sw_trig_i,
  input  logic [N_HW_TRIG-1:0]                 hw_trig_i,
  output logic [NUM_CH*DATA_W-1:0]             code_o
);

  localparam int STRIDE = wg_pkg::CH_STRIDE;
  localparam int USED   = wg_pkg::CFG_USED;
  localparam int RSVD_W = STRIDE - USED;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_CH-1:0] unused_rsvd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wg_pkg::chan_cfg_t cfg;

    assign cfg            = wg_pkg::unpack_cfg(ctrl_i[c*STRIDE +: USED]);
    assign unused_rsvd[c] = ^ctrl_i[c*STRIDE+USED +: RSVD_W];

    wg_channel #(
      .DATA_W (DATA_W),
      .N_HW   (N_HW_TRIG),
      .SEED   (SEED)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .cfg_i  (cfg),
      .base_i (base_i[c*DATA_W +: DATA_W]),
      .sw_i   (sw_trig_i[c]),
      .hw_i   (hw_trig_i),
      .code_o (code_o[c*DATA_W +: DATA_W])
    );
  end

endmodule

// File: tb/wavegen_dual_tb.sv
module wavegen_dual_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 60000;
  localparam int N_VEC      = 12;

  // Vector: {channel-1 control half, base, expected code after one software trigger}
  // Control 0x0061: enable, source 0 (software), mode 10 triangle (R1), selector 1 -> peak 3.
  localparam logic [39:0] VEC [N_VEC] = '{
    {16'h0061, 12'h100, 12'h101},
    {16'h0061, 12'h100, 12'h102},
    {16'h0061, 12'h100, 12'h103},
    {16'h0061, 12'h100, 12'h102},
    {16'h0061, 12'h100, 12'h101},
    {16'h0061, 12'h100, 12'h100},
    {16'h0061, 12'h100, 12'h101},
    {16'h0061, 12'hFFE, 12'h000},
    {16'h0061, 12'hFFE, 12'h001},
    {16'h0061, 12'hFFE, 12'h000},
    {16'h0061, 12'hFFE, 12'hFFF},
    {16'h0061, 12'hFFE, 12'hFFE}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] ctrl;
  logic [23:0] base;
  logic [1:0]  sw;
  logic [6:0]  hw;
  logic [23:0] code;

  int checks = 0;
  int errors = 0;
  logic [11:0] lf;
  logic [11:0] held;

  wavegen_dual u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (ctrl),
    .base_i    (base),
    .sw_trig_i (sw),
    .hw_trig_i (hw),
    .code_o    (code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] lfsr_next(input logic [11:0] v);
    return {v[10:0], v[11] ^ v[10] ^ v[9] ^ v[3]};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set1(input logic [15:0] c, input logic [11:0] b);
    @(negedge clk);
    ctrl[15:0] = c;
    base[11:0] = b;
  endtask

  task automatic pulse_sw(input int ch);
    @(negedge clk);
    sw[ch] = 1'b1;
    @(negedge clk);
    sw[ch] = 1'b0;
  endtask

  task automatic pulse_hw(input int k);
    @(negedge clk);
    hw[k] = 1'b1;
    @(negedge clk);
    hw[k] = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl  = '0;
    base  = {12'h000, 12'h123};
    sw    = '0;
    hw    = '0;
    repeat (3) @(negedge clk);
    chk("R11 ch1 in reset", code[11:0], 12'h000);
    chk("R11 ch2 in reset", code[23:12], 12'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // Trigger enable is 0 after reset: output follows base.
    chk("R9 follow base after reset", code[11:0], 12'h123);

    // Table walk: triangle peak 3 with wrap at 12 bits.
    for (int i = 0; i < N_VEC; i++) begin
      set1(VEC[i][39:24], VEC[i][23:12]);
      pulse_sw(0);
      chk($sformatf("R3/R6 triangle vector %0d", i), code[11:0], VEC[i][11:0]);
    end

    // Noise, selector 3 (0x00D1): mask bits [3:0].
    lf = 12'hAAA;
    set1(16'h00D1, 12'h200);
    for (int i = 0; i < 6; i++) begin
      pulse_sw(0);
      lf = lfsr_next(lf);
      chk("R4/R5 noise selector 3", code[11:0], 12'h200 + (lf & 12'h00F));
    end
    // Selector 15 (0x03D1): all 12 bits, sum wraps.
    set1(16'h03D1, 12'h800);
    for (int i = 0; i < 3; i++) begin
      pulse_sw(0);
      lf = lfsr_next(lf);
      chk("R4 noise selector saturates", code[11:0], 12'h800 + lf);
    end

    // Mode 00 and 11 load base on trigger.
    set1(16'h0001, 12'h345);
    pulse_sw(0);
    chk("R7 mode 00 loads base", code[11:0], 12'h345);
    set1(16'h0031, 12'h222);
    pulse_sw(0);
    chk("R7 mode 11 loads base", code[11:0], 12'h222);
    // Noise register did not move in the other modes.
    set1(16'h03D1, 12'h000);
    pulse_sw(0);
    lf = lfsr_next(lf);
    chk("R5 noise steps only in noise mode", code[11:0], lf);

    // Hold without trigger.
    held = code[11:0];
    set1(16'h03D1, 12'h5A5);
    repeat (3) @(negedge clk);
    chk("R8 hold on base change", code[11:0], held);

    // Hardware trigger source 2 (bits[3:1]=2): control 0x0005.
    set1(16'h0005, 12'h777);
    pulse_hw(1);
    chk("R2 hw line 1 fires on source 2", code[11:0], 12'h777);
    set1(16'h0005, 12'h111);
    pulse_sw(0);
    chk("R2 sw ignored on source 2", code[11:0], 12'h777);
    pulse_hw(0);
    chk("R2 other hw line ignored", code[11:0], 12'h777);
    pulse_hw(1);
    chk("R2 hw line 1 fires again", code[11:0], 12'h111);
    set1(16'h000F, 12'h0AB);
    pulse_hw(6);
    chk("R2 source 7 uses hw line 6", code[11:0], 12'h0AB);

    // Trigger disable freezes triangle (0x00A1: peak 7).
    set1(16'h00A1, 12'h300);
    pulse_sw(0);
    chk("R3 peak 7 step 1", code[11:0], 12'h301);
    pulse_sw(0);
    chk("R3 peak 7 step 2", code[11:0], 12'h302);
    set1(16'h00A0, 12'h040);
    @(negedge clk);
    chk("R9 disabled follows base", code[11:0], 12'h040);
    base[11:0] = 12'h041;
    pulse_sw(0);
    chk("R9 disabled ignores trigger", code[11:0], 12'h041);
    set1(16'h00A1, 12'h300);
    pulse_sw(0);
    chk("R9 counter not advanced while disabled", code[11:0], 12'h303);

    // Mode change clears counter and direction.
    set1(16'h0001, 12'h300);
    set1(16'h0061, 12'h300);
    pulse_sw(0);
    pulse_sw(0);
    pulse_sw(0);
    chk("R10 reached peak 3", code[11:0], 12'h303);
    set1(16'h0011, 12'h300);
    set1(16'h0061, 12'h300);
    pulse_sw(0);
    chk("R10 restart from zero rising", code[11:0], 12'h301);

    // Channel 2 at bits [31:16] (R1), independent of channel 1.
    held = code[11:0];
    @(negedge clk);
    ctrl[31:16] = 16'h0021;
    base[23:12] = 12'h010;
    pulse_sw(1);
    chk("R12 ch2 triangle step", code[23:12], 12'h011);
    pulse_sw(1);
    chk("R12 ch2 triangle turn", code[23:12], 12'h010);
    chk("R12 ch1 untouched by ch2", code[11:0], held);

    // Full-scale triangle with selector 13 (0x0361).
    set1(16'h0001, 12'h000);
    set1(16'h0361, 12'h000);
    for (int i = 0; i < 4095; i++) begin
      pulse_sw(0);
    end
    chk("R3 saturated peak 4095", code[11:0], 12'hFFF);
    pulse_sw(0);
    chk("R3 turn below 4095", code[11:0], 12'hFFE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule